// File: doc/BRIEF.md
# Capacitive Touch Baseline and Threshold Tracker

This block sits behind the measurement front end of one capacitive sensing channel and turns the stream of per-scan counts into touch events. Software seeds a baseline value. While tracing is allowed, the block slowly drags that baseline toward each new in-range count. The step size scales with the baseline itself, so a drifting sensor is followed at a rate set by a ratio code. The high and low detection thresholds can be derived from the baseline by a shift ratio, or software can write them directly.

Every count is compared against the current thresholds. A run of consecutive out-of-range counts passes through a debounce counter before it raises the out-of-range flag. An end-of-scan flag is raised for every count with no filtering. Both flags are sticky and are cleared by a one-cycle clear pulse. Whenever the scanned channel changes, software must reload the baseline and, if thresholds are not derived, the thresholds.

Top module: `cap_trk_top`

## Requirements
- R1: After reset, the baseline, both thresholds and both flags read zero.
- R2: A `base_wr` pulse loads `base_wdata` into the baseline on that clock edge. It takes priority over any tracing step in the same cycle.
- R3: A tracing step moves the baseline toward the sample by max(1, baseline >> (`trace_ratio`+1)). When the remaining distance is not larger than that step, the baseline becomes exactly the sample and never passes it.
- R4: A tracing step happens only on a sample while both `trace_en` and `lp_mode` are 1. Otherwise the baseline holds.
- R5: A sample that is out of range never moves the baseline.
- R6: While `thr_trace_en` is 1, on every clock edge the thresholds load high = baseline + (baseline >> (`thr_ratio`+1)), saturated at 0xFFFF, and low = baseline − (baseline >> (`thr_ratio`+1)). Both use the baseline as it was before that edge.
- R7: While `thr_trace_en` is 0, a `thr_wr` pulse loads `thr_hi_wdata` and `thr_lo_wdata`. While `thr_trace_en` is 1, `thr_wr` has no effect.
- R8: A sample is out of range when it is strictly greater than the high threshold or strictly less than the low threshold. A sample equal to either threshold is in range.
- R9: The out-of-range flag sets on the sample where the count of consecutive out-of-range samples reaches `db_count`, where a `db_count` of 0 acts as 1. Any in-range sample restarts the count at zero.
- R10: The end-of-scan flag sets on the edge of every sample, whatever its value.
- R11: Each flag is cleared by its clear pulse on the next edge. A set and a clear in the same cycle leave the flag set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| samp_vld | input | 1 | One-cycle strobe: a new count is present |
| samp_cnt | input | 16 | Capacitance count of the finished scan |
| base_wr | input | 1 | Load pulse for the baseline |
| base_wdata | input | 16 | Baseline value to load |
| trace_en | input | 1 | Allow baseline tracing |
| lp_mode | input | 1 | Low-power mode indicator; tracing runs only while it is 1 |
| trace_ratio | input | 3 | Tracing step shift code |
| thr_trace_en | input | 1 | Derive thresholds from the baseline |
| thr_ratio | input | 3 | Threshold margin shift code |
| thr_wr | input | 1 | Direct threshold load pulse |
| thr_hi_wdata | input | 16 | High threshold to load |
| thr_lo_wdata | input | 16 | Low threshold to load |
| db_count | input | 4 | Consecutive out-of-range samples needed to raise the flag |
| eos_clr | input | 1 | Clear pulse for the end-of-scan flag |
| oor_clr | input | 1 | Clear pulse for the out-of-range flag |
| baseline | output | 16 | Current baseline |
| thr_hi | output | 16 | Current high threshold |
| thr_lo | output | 16 | Current low threshold |
| eos_irq | output | 1 | Sticky end-of-scan flag |
| oor_irq | output | 1 | Sticky out-of-range flag |

## Verification
On every cycle, the assertions check these invariants:
- the baseline holds outside low-power mode and on out-of-range samples;
- an upward tracing step never passes the sample;
- derived thresholds stay ordered;
- an in-range sample empties the debounce counter;
- a clear without a competing set drops a flag.

Exact step sizes, the saturation of the high threshold, equality at a threshold, the zero debounce setting and the write priority are shown by the bench. It does this in directed scenarios with hand-computed values and in a long random run checked against its behavioural model.

// File: rtl/trk_pkg.sv
package trk_pkg;
  localparam int unsigned CNT_W = 16;
  localparam int unsigned RAT_W = 3;
  localparam int unsigned DB_W  = 4;
endpackage

// File: rtl/trk_step.sv
module trk_step #(
  parameter int unsigned W  = 16,
  parameter int unsigned RW = 3
) (
  input  logic [W-1:0]  base,
  input  logic [W-1:0]  samp,
  input  logic [RW-1:0] ratio,
  output logic [W-1:0]  nxt
);
  localparam int unsigned SW = RW + 1;

  logic [SW-1:0] sh;
  logic [W-1:0]  raw, step, diff;
  logic          up;

  always_comb begin
    sh   = SW'(ratio) + SW'(1);
    raw  = base >> sh;
    step = (raw == '0) ? W'(1) : raw;
    up   = samp > base;
    diff = up ? (samp - base) : (base - samp);
    if (diff <= step) nxt = samp;
    else if (up)      nxt = base + step;
    else              nxt = base - step;
  end
endmodule

// File: rtl/trk_thresh.sv
module trk_thresh #(
  parameter int unsigned W  = 16,
  parameter int unsigned RW = 3
) (
  input  logic [W-1:0]  base,
  input  logic [RW-1:0] ratio,
  output logic [W-1:0]  hi,
  output logic [W-1:0]  lo
);
  localparam int unsigned SW = RW + 1;

  logic [SW-1:0] sh;
  logic [W-1:0]  margin;
  logic [W:0]    sum;

  always_comb begin
    sh     = SW'(ratio) + SW'(1);
    margin = base >> sh;
    sum    = {1'b0, base} + {1'b0, margin};
    hi     = sum[W] ? '1 : sum[W-1:0];
    lo     = base - margin;
  end
endmodule

// File: rtl/trk_debounce.sv
module trk_debounce #(
  parameter int unsigned DW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          vld,
  input  logic          oor,
  input  logic [DW-1:0] limit,
  input  logic          clr,
  output logic          irq
);
  logic [DW-1:0] cnt_q, cnt_d, lim;
  logic          irq_q, irq_d, fire, cnt_en;

  always_comb begin
    lim    = (limit == '0) ? DW'(1) : limit;
    cnt_en = vld;
    cnt_d  = cnt_q;
    fire   = 1'b0;
    if (vld) begin
      if (oor) begin
        cnt_d = (cnt_q == '1) ? cnt_q : cnt_q + DW'(1);
        fire  = cnt_d >= lim;
      end else begin
        cnt_d = '0;
      end
    end
    irq_d = fire ? 1'b1 : (clr ? 1'b0 : irq_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      irq_q <= 1'b0;
    end else begin
      if (cnt_en) cnt_q <= cnt_d;
      irq_q <= irq_d;
    end
  end

  assign irq = irq_q;

  AST_DB_INRANGE_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    vld && !oor |=> cnt_q == '0); // R9
  AST_OOR_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    clr && !(vld && oor) |=> !irq_q); // R11
endmodule

// File: rtl/cap_trk_top.sv
module cap_trk_top #(
  parameter int unsigned CNT_W = trk_pkg::CNT_W,
  parameter int unsigned RAT_W = trk_pkg::RAT_W,
  parameter int unsigned DB_W  = trk_pkg::DB_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             samp_vld,
  input  logic [CNT_W-1:0] samp_cnt,
  input  logic             base_wr,
  input  logic [CNT_W-1:0] base_wdata,
  input  logic             trace_en,
  input  logic             lp_mode,
  input  logic [RAT_W-1:0] trace_ratio,
  input  logic             thr_trace_en,
  input  logic [RAT_W-1:0] thr_ratio,
  input  logic             thr_wr,
  input  logic [CNT_W-1:0] thr_hi_wdata,
  input  logic [CNT_W-1:0] thr_lo_wdata,
  input  logic [DB_W-1:0]  db_count,
  input  logic             eos_clr,
  input  logic             oor_clr,
  output logic [CNT_W-1:0] baseline,
  output logic [CNT_W-1:0] thr_hi,
  output logic [CNT_W-1:0] thr_lo,
  output logic             eos_irq,
  output logic             oor_irq
);
  logic [CNT_W-1:0] base_q, base_d, step_nxt;
  logic [CNT_W-1:0] hi_q, lo_q, hi_d, lo_d, calc_hi, calc_lo;
  logic             base_en, thr_en, trace_go, oor_now;
  logic             eos_q, eos_d;

  trk_step #(.W(CNT_W), .RW(RAT_W)) u_step (
    .base(base_q), .samp(samp_cnt), .ratio(trace_ratio), .nxt(step_nxt)
  );

  trk_thresh #(.W(CNT_W), .RW(RAT_W)) u_thr (
    .base(base_q), .ratio(thr_ratio), .hi(calc_hi), .lo(calc_lo)
  );

  trk_debounce #(.DW(DB_W)) u_db (
    .clk(clk), .rst_n(rst_n), .vld(samp_vld), .oor(oor_now),
    .limit(db_count), .clr(oor_clr), .irq(oor_irq)
  );

  always_comb begin
    oor_now  = samp_vld && ((samp_cnt > hi_q) || (samp_cnt < lo_q));
    trace_go = samp_vld && trace_en && lp_mode && !oor_now;
    base_en  = base_wr || trace_go;
    base_d   = base_wr ? base_wdata : step_nxt;
    thr_en   = thr_trace_en || thr_wr;
    hi_d     = thr_trace_en ? calc_hi : thr_hi_wdata;
    lo_d     = thr_trace_en ? calc_lo : thr_lo_wdata;
    eos_d    = samp_vld ? 1'b1 : (eos_clr ? 1'b0 : eos_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      hi_q   <= '0;
      lo_q   <= '0;
      eos_q  <= 1'b0;
    end else begin
      if (base_en) base_q <= base_d;
      if (thr_en) begin
        hi_q <= hi_d;
        lo_q <= lo_d;
      end
      eos_q <= eos_d;
    end
  end

  assign baseline = base_q;
  assign thr_hi   = hi_q;
  assign thr_lo   = lo_q;
  assign eos_irq  = eos_q;

  AST_TRACE_NO_OVERSHOOT: assert property (@(posedge clk) disable iff (!rst_n)
    trace_go && !base_wr && (samp_cnt >= base_q)
    |=> (base_q <= $past(samp_cnt)) && (base_q >= $past(base_q))); // R3
  AST_HOLD_OUTSIDE_LP: assert property (@(posedge clk) disable iff (!rst_n)
    !lp_mode && !base_wr |=> $stable(base_q)); // R4
  AST_FREEZE_ON_OOR: assert property (@(posedge clk) disable iff (!rst_n)
    oor_now && !base_wr |=> $stable(base_q)); // R5
  AST_THR_ORDERED: assert property (@(posedge clk) disable iff (!rst_n)
    thr_trace_en |=> lo_q <= hi_q); // R6
  AST_EOS_SET: assert property (@(posedge clk) disable iff (!rst_n)
    samp_vld |=> eos_q); // R10
  AST_EOS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    eos_clr && !samp_vld |=> !eos_q); // R11
endmodule

// File: tb/cap_trk_top_test.sv
`timescale 1ns/1ps
module cap_trk_top_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic samp_vld = 0, base_wr = 0, trace_en = 0, lp_mode = 0;
  logic thr_trace_en = 0, thr_wr = 0, eos_clr = 0, oor_clr = 0;
  logic [15:0] samp_cnt = 0, base_wdata = 0, thr_hi_wdata = 0, thr_lo_wdata = 0;
  logic [2:0]  trace_ratio = 0, thr_ratio = 0;
  logic [3:0]  db_count = 0;
  logic [15:0] baseline, thr_hi, thr_lo;
  logic        eos_irq, oor_irq;

  int total = 0, bad = 0;
  int m_base = 0, m_hi = 0, m_lo = 0, m_cnt = 0;
  bit m_eos = 0, m_oor = 0;

  always #2 clk = ~clk;

  cap_trk_top uut (
    .clk(clk), .rst_n(rst_n), .samp_vld(samp_vld), .samp_cnt(samp_cnt),
    .base_wr(base_wr), .base_wdata(base_wdata), .trace_en(trace_en),
    .lp_mode(lp_mode), .trace_ratio(trace_ratio), .thr_trace_en(thr_trace_en),
    .thr_ratio(thr_ratio), .thr_wr(thr_wr), .thr_hi_wdata(thr_hi_wdata),
    .thr_lo_wdata(thr_lo_wdata), .db_count(db_count), .eos_clr(eos_clr),
    .oor_clr(oor_clr), .baseline(baseline), .thr_hi(thr_hi), .thr_lo(thr_lo),
    .eos_irq(eos_irq), .oor_irq(oor_irq)
  );

  // Behavioural reference model, updated on each clock edge from pre-edge state.
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_base = 0; m_hi = 0; m_lo = 0; m_cnt = 0; m_eos = 0; m_oor = 0;
    end else begin
      int nb, nh, nl, st, d, lim, sc;
      bit out, hit;
      sc  = samp_cnt;
      out = samp_vld && (sc > m_hi || sc < m_lo);
      nb  = m_base;
      if (base_wr) nb = base_wdata;
      else if (samp_vld && trace_en && lp_mode && !out) begin
        st = m_base >> (trace_ratio + 1);
        if (st == 0) st = 1;
        if (sc > m_base) nb = (sc - m_base <= st) ? sc : m_base + st;
        else if (sc < m_base) nb = (m_base - sc <= st) ? sc : m_base - st;
      end
      nh = m_hi; nl = m_lo;
      if (thr_trace_en) begin
        d  = m_base >> (thr_ratio + 1);
        nh = (m_base + d > 65535) ? 65535 : m_base + d;
        nl = m_base - d;
      end else if (thr_wr) begin
        nh = thr_hi_wdata; nl = thr_lo_wdata;
      end
      hit = 0;
      if (samp_vld) begin
        if (out) begin
          if (m_cnt < 15) m_cnt = m_cnt + 1;
          lim = (db_count == 0) ? 1 : db_count;
          hit = (m_cnt >= lim);
        end else m_cnt = 0;
      end
      if (hit) m_oor = 1; else if (oor_clr) m_oor = 0;
      if (samp_vld) m_eos = 1; else if (eos_clr) m_eos = 0;
      m_base = nb; m_hi = nh; m_lo = nl;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // Cycle-by-cycle comparison against the model.
  always @(negedge clk) begin
    if (rst_n) begin
      chk("R3 baseline vs model", baseline, m_base);
      chk("R6 thr_hi vs model", thr_hi, m_hi);
      chk("R7 thr_lo vs model", thr_lo, m_lo);
      chk("R10 eos vs model", eos_irq, m_eos);
      chk("R9 oor vs model", oor_irq, m_oor);
    end
  end

  task automatic idle();
    @(negedge clk);
  endtask

  task automatic samp(input int v);
    samp_vld = 1; samp_cnt = 16'(v);
    @(negedge clk);
    samp_vld = 0;
  endtask

  task automatic wr_base(input int v);
    base_wr = 1; base_wdata = 16'(v);
    @(negedge clk);
    base_wr = 0;
  endtask

  task automatic wr_thr(input int h, input int l);
    thr_wr = 1; thr_hi_wdata = 16'(h); thr_lo_wdata = 16'(l);
    @(negedge clk);
    thr_wr = 0;
  endtask

  initial begin
    #400000;
    bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    idle();
    chk("R1 baseline", baseline, 0);
    chk("R1 thr_hi", thr_hi, 0);
    chk("R1 thr_lo", thr_lo, 0);
    chk("R1 eos", eos_irq, 0);
    chk("R1 oor", oor_irq, 0);

    wr_base(1000);
    chk("R2 base load", baseline, 1000);
    thr_trace_en = 1; thr_ratio = 2;
    idle(); idle();
    chk("R6 hi derived", thr_hi, 1125);
    chk("R6 lo derived", thr_lo, 875);

    trace_en = 1; lp_mode = 1; trace_ratio = 3;
    samp(1100);
    chk("R3 step 62", baseline, 1062);
    chk("R10 eos on sample", eos_irq, 1);
    samp(1070);
    chk("R3 no overshoot", baseline, 1070);
    lp_mode = 0;
    samp(1100);
    chk("R4 hold outside lp", baseline, 1070);

    lp_mode = 1; db_count = 2;
    idle();
    chk("R6 hi follows", thr_hi, 1203);
    samp(1300);
    chk("R5 frozen on oor", baseline, 1070);
    chk("R9 first oor no irq", oor_irq, 0);
    lp_mode = 0;
    samp(1203);
    chk("R8 equal in range", oor_irq, 0);
    samp(1300);
    chk("R9 count restarted", oor_irq, 0);
    samp(1300);
    chk("R9 irq at count", oor_irq, 1);

    oor_clr = 1; idle(); oor_clr = 0;
    chk("R11 oor cleared", oor_irq, 0);
    eos_clr = 1; samp(1300); eos_clr = 0;
    chk("R11 set beats clear", eos_irq, 1);
    eos_clr = 1; idle(); eos_clr = 0;
    chk("R11 eos cleared", eos_irq, 0);

    wr_thr(5, 4);
    chk("R7 write ignored hi", thr_hi, 1203);
    chk("R7 write ignored lo", thr_lo, 937);
    thr_trace_en = 0;
    wr_thr(500, 100);
    chk("R7 direct hi", thr_hi, 500);
    chk("R7 direct lo", thr_lo, 100);
    oor_clr = 1; idle(); oor_clr = 0;
    db_count = 0;
    samp(50);
    chk("R9 zero acts as one, R8 below", oor_irq, 1);

    wr_base(16'hF000);
    thr_trace_en = 1; thr_ratio = 0;
    idle(); idle();
    chk("R6 hi saturates", thr_hi, 16'hFFFF);
    chk("R6 lo", thr_lo, 16'h7800);

    thr_trace_en = 0;
    wr_thr(16'hFFFF, 0);
    wr_base(5);
    trace_ratio = 7; lp_mode = 1; trace_en = 1;
    samp(10);
    chk("R3 minimum step", baseline, 6);
    base_wr = 1; base_wdata = 77; samp(10); base_wr = 0;
    chk("R2 write beats trace", baseline, 77);

    for (int i = 0; i < 3000; i++) begin
      int c;
      samp_vld = ($urandom % 10) < 6;
      c = m_base + int'($urandom % 400) - 200;
      if (c < 0) c = 0;
      if (c > 65535) c = 65535;
      samp_cnt = 16'(c);
      base_wr = ($urandom % 40) == 0;
      base_wdata = 16'($urandom);
      thr_wr = ($urandom % 30) == 0;
      thr_hi_wdata = 16'(m_base + 100 + ($urandom % 200));
      thr_lo_wdata = 16'((m_base > 300) ? m_base - 100 - ($urandom % 200) : 0);
      if (($urandom % 25) == 0) trace_en = ~trace_en;
      if (($urandom % 25) == 0) lp_mode = ~lp_mode;
      if (($urandom % 40) == 0) thr_trace_en = ~thr_trace_en;
      trace_ratio = 3'($urandom);
      if (($urandom % 20) == 0) thr_ratio = 3'($urandom);
      if (($urandom % 50) == 0) db_count = 4'($urandom);
      eos_clr = ($urandom % 8) == 0;
      oor_clr = ($urandom % 8) == 0;
      @(negedge clk);
    end
    samp_vld = 0; base_wr = 0; thr_wr = 0; eos_clr = 0; oor_clr = 0;
    idle();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule